// File: doc/BRIEF.md
# Extended Parallel Port Control Window with Test FIFO

This block implements the extended register window of a parallel port controller. Software reaches it through eight byte-wide locations. Location 0 is the data/FIFO port, location 1 holds a general-purpose configuration byte, and location 2 is the extended control register. The extended control register carries a three-bit operating mode and two read-only FIFO occupancy flags. The remaining locations have no function.

A small byte FIFO, two entries deep by default, can be reached only when the mode field selects FIFO test. In that mode, a write to location 0 pushes a byte and a read pops one. In every other mode, location 0 acts as a plain storage byte. The configuration mode is the exception for reads: there, location 0 returns a fixed configuration byte that reports the port word width. Any write that changes the mode field empties the FIFO. Software can therefore always start a FIFO test from a known empty state.

Reads are registered. The byte addressed in a read cycle appears on the read-data output after the next rising clock edge, and it holds there until the next read.

Top module: `ecp_ext_regs`

## Requirements
- R1: After reset, the control register at location 2 reads 0x01 (mode 000, empty flag), location 1 reads 0x00, and location 0 reads 0x00.
- R2: A write to location 2 replaces the mode with write bits 7:5. Write bits 4:0 are ignored. The register reads as {mode[2:0], 3'b000, flags[1:0]}. Mode codes are 000 compatibility, 001 byte, 010 port FIFO, 011 extended FIFO, 100 address/data strobe, 101 reserved, 110 FIFO test and 111 configuration.
- R3: In FIFO-test mode (110), a write to location 0 pushes a byte and a read of location 0 pops the oldest byte. The FIFO holds DEPTH bytes (default 2), and both pointers wrap to the first slot after the last.
- R4: Control register bits 1:0 read 01 when the FIFO is empty, 10 when it holds DEPTH bytes, and 00 otherwise.
- R5: A control register write whose bits 7:5 differ from the current mode empties the FIFO. A write that keeps the same mode leaves the FIFO contents and flags unchanged.
- R6: Outside FIFO-test mode, location 0 is a read/write byte register. Writes to it never touch the FIFO, and FIFO traffic never changes it.
- R7: In configuration mode (111), a read of location 0 returns the width byte. Its bits 6:4 are 001 for WORD_BYTES=1, 000 for 2 and 010 for 4, and all other bits are 0. A write to location 0 in this mode still updates the plain byte register.
- R8: A push while the FIFO is full is dropped, and the stored bytes are kept. A pop while it is empty returns 0xFF and leaves the flags at empty.
- R9: Location 1 is a read/write byte register.
- R10: Reads of locations 3 to 7 return 0xFF. Writes to them change no register.
- R11: A read updates the read-data output at the first rising edge after it is presented, and the output holds its value in cycles with no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register location within the window |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |

## Verification
Internal errors in this block show up at the ports, and the bench looks for them there. A wrong FIFO pointer shows up on the first pop after it goes wrong: bytes come back out of order, or a stale byte returns. A wrong occupancy count shows up on the next read of location 2 as a wrong flag pair. It can also appear as a byte that was dropped or accepted when it should not have been. A mode register that fails to flush, or flushes when it should not, is seen at the next pop, where the byte returned differs from the expected 0xFF or the expected data. The fill, wrap, overflow and underflow sequences are built so that each of these faults is observable within one or two accesses.

// File: rtl/ecp_pkg.sv
package ecp_pkg;

   typedef enum logic [2:0] {
      MODE_COMPAT  = 3'b000,
      MODE_BYTE    = 3'b001,
      MODE_PPFIFO  = 3'b010,
      MODE_XFIFO   = 3'b011,
      MODE_STROBED = 3'b100,
      MODE_RSVD    = 3'b101,
      MODE_FTEST   = 3'b110,
      MODE_CONFIG  = 3'b111
   } ecp_mode_e;

   localparam logic [1:0] FLAGS_SOME  = 2'b00;
   localparam logic [1:0] FLAGS_EMPTY = 2'b01;
   localparam logic [1:0] FLAGS_FULL  = 2'b10;

   localparam logic [2:0] LOC_DATA = 3'd0;
   localparam logic [2:0] LOC_CFGB = 3'd1;
   localparam logic [2:0] LOC_CTRL = 3'd2;

   localparam logic [7:0] IDLE_READ = 8'hFF;

   // width code reported in configuration mode
   function automatic logic [2:0] width_code(input int bytes);
      case (bytes)
         1:       return 3'b001;
         2:       return 3'b000;
         4:       return 3'b010;
         default: return 3'b111;
      endcase
   endfunction

endpackage

// File: rtl/ecp_fifo.sv
module ecp_fifo #(
   parameter  int DEPTH = 2,
   parameter  int DW    = 8,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic             pop,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    head,
   output logic [CNT_W-1:0] count,
   output logic             empty,
   output logic             full
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("ecp_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [DW-1:0]    slot [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic             push_ok, pop_ok;

   function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign empty   = (count == '0);
   assign full    = (count == CNT_W'(DEPTH));
   assign push_ok = push && !full && !flush;
   assign pop_ok  = pop && !empty && !flush;
   assign head    = slot[rd_ptr];

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         always_ff @(posedge clk) begin
            if (push_ok && (wr_ptr == PTR_W'(g))) slot[g] <= wdata;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= step(wr_ptr);
         if (pop_ok)  rd_ptr <= step(rd_ptr);
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/ecp_mode_reg.sv
module ecp_mode_reg
   import ecp_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      we,
   input  logic [2:0] wmode,
   output ecp_mode_e mode,
   output logic      flush
);

   assign flush = we && (wmode != mode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mode <= MODE_COMPAT;
      else if (we) mode <= ecp_mode_e'(wmode);
   end

endmodule

// File: rtl/ecp_byte_reg.sv
module ecp_byte_reg #(
   parameter int         DW        = 8,
   parameter logic [7:0] RESET_VAL = 8'h00
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [DW-1:0] d,
   output logic [DW-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= DW'(RESET_VAL);
      else if (we) q <= d;
   end

endmodule

// File: rtl/ecp_ext_regs.sv
module ecp_ext_regs
   import ecp_pkg::*;
#(
   parameter int DEPTH      = 2,
   parameter int WORD_BYTES = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] bus_addr,
   input  logic       bus_wr,
   input  logic       bus_rd,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata
);

   localparam int         CNT_W    = $clog2(DEPTH + 1);
   localparam logic [7:0] CFGA_VAL = {1'b0, width_code(WORD_BYTES), 4'b0000};

   generate
      if (!(WORD_BYTES == 1 || WORD_BYTES == 2 || WORD_BYTES == 4)) begin : g_bad_width
         $error("ecp_ext_regs: WORD_BYTES must be 1, 2 or 4");
      end
   endgenerate

   ecp_mode_e        cur_mode;
   logic             flush, in_test, in_config;
   logic             hit_data, hit_cfgb, hit_ctrl;
   logic             fifo_push, fifo_pop, plain_we;
   logic [7:0]       fifo_head, data_q, cfgb_q, rd_next;
   logic [CNT_W-1:0] fifo_count;
   logic             fifo_empty, fifo_full;
   logic [1:0]       flags;

   assign hit_data  = (bus_addr == LOC_DATA);
   assign hit_cfgb  = (bus_addr == LOC_CFGB);
   assign hit_ctrl  = (bus_addr == LOC_CTRL);
   assign in_test   = (cur_mode == MODE_FTEST);
   assign in_config = (cur_mode == MODE_CONFIG);

   assign fifo_push = bus_wr && hit_data && in_test;
   assign fifo_pop  = bus_rd && hit_data && in_test;
   assign plain_we  = bus_wr && hit_data && !in_test;

   ecp_mode_reg u_mode (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bus_wr && hit_ctrl),
      .wmode (bus_wdata[7:5]),
      .mode  (cur_mode),
      .flush (flush)
   );

   ecp_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .push  (fifo_push),
      .pop   (fifo_pop),
      .wdata (bus_wdata),
      .head  (fifo_head),
      .count (fifo_count),
      .empty (fifo_empty),
      .full  (fifo_full)
   );

   ecp_byte_reg #(.DW(8), .RESET_VAL(8'h00)) u_data (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (plain_we),
      .d     (bus_wdata),
      .q     (data_q)
   );

   ecp_byte_reg #(.DW(8), .RESET_VAL(8'h00)) u_cfgb (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bus_wr && hit_cfgb),
      .d     (bus_wdata),
      .q     (cfgb_q)
   );

   always_comb begin
      if (fifo_empty)     flags = FLAGS_EMPTY;
      else if (fifo_full) flags = FLAGS_FULL;
      else                flags = FLAGS_SOME;
   end

   always_comb begin
      case (bus_addr)
         LOC_DATA: begin
            if (in_test)        rd_next = fifo_empty ? IDLE_READ : fifo_head;
            else if (in_config) rd_next = CFGA_VAL;
            else                rd_next = data_q;
         end
         LOC_CFGB: rd_next = cfgb_q;
         LOC_CTRL: rd_next = {cur_mode, 3'b000, flags};
         default:  rd_next = IDLE_READ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= 8'h00;
      else if (bus_rd) bus_rdata <= rd_next;
   end

endmodule

// File: rtl/ecp_ext_regs_chk.sv
module ecp_ext_regs_chk #(
   parameter  int DEPTH = 2,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       bus_addr,
   input logic             bus_wr,
   input logic             bus_rd,
   input logic [2:0]       wr_mode,
   input logic [7:0]       bus_rdata,
   input logic [2:0]       mode,
   input logic [CNT_W-1:0] fifo_count
);

   localparam logic [2:0] TEST = 3'b110;

   assert_push_counts_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 3'd0 && mode == TEST && fifo_count < CNT_W'(DEPTH))
      |=> (fifo_count == CNT_W'($past(fifo_count) + 1)));

   assert_count_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_count <= CNT_W'(DEPTH));

   assert_flush_on_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 3'd2 && wr_mode != mode)
      |=> (fifo_count == '0 && mode == $past(wr_mode)));

   assert_fifo_idle_outside_test_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != TEST) |-> (fifo_count == '0));

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 3'd0 && mode == TEST && fifo_count == CNT_W'(DEPTH))
      |=> (fifo_count == CNT_W'(DEPTH)));

   assert_underflow_ff_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == 3'd0 && mode == TEST && fifo_count == '0)
      |=> (bus_rdata == 8'hFF && fifo_count == '0));

   assert_unused_reads_ff_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr >= 3'd3) |=> (bus_rdata == 8'hFF));

   assert_rdata_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rd) |=> $stable(bus_rdata));

endmodule

bind ecp_ext_regs ecp_ext_regs_chk #(.DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_wr     (bus_wr),
   .bus_rd     (bus_rd),
   .wr_mode    (bus_wdata[7:5]),
   .bus_rdata  (bus_rdata),
   .mode       (cur_mode),
   .fifo_count (fifo_count)
);

// File: tb/ecp_ext_regs_test.sv
module ecp_ext_regs_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ecp_ext_regs #(.DEPTH(2), .WORD_BYTES(1)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata)
   );

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic rd_check(input string tag, input logic [2:0] a, input logic [7:0] exp);
      logic [7:0] v;
      rd(a, v);
      check(tag, v, exp);
   endtask

   task automatic t_reset;
      rd_check("R1 control after reset", 3'd2, 8'h01);
      rd_check("R1 cfgB after reset", 3'd1, 8'h00);
      rd_check("R1 data after reset", 3'd0, 8'h00);
   endtask

   task automatic t_mode_write;
      wr(3'd2, 8'h3F);
      rd_check("R2 mode replaced, low bits ignored", 3'd2, 8'h21);
      wr(3'd2, 8'h80);
      rd_check("R2 mode 100 readback", 3'd2, 8'h81);
      wr(3'd2, 8'h00);
      rd_check("R2 back to compat", 3'd2, 8'h01);
   endtask

   task automatic t_cfgb;
      wr(3'd1, 8'hC3);
      rd_check("R9 cfgB readback", 3'd1, 8'hC3);
      wr(3'd1, 8'h3C);
      rd_check("R9 cfgB rewrite", 3'd1, 8'h3C);
   endtask

   task automatic t_plain;
      wr(3'd0, 8'hA5);
      rd_check("R6 plain data readback", 3'd0, 8'hA5);
      rd_check("R6 FIFO untouched by plain write", 3'd2, 8'h01);
   endtask

   task automatic t_config;
      wr(3'd2, 8'hE0);
      rd_check("R7 width byte in config mode", 3'd0, 8'h10);
      wr(3'd0, 8'h5A);
      rd_check("R7 width byte after write", 3'd0, 8'h10);
      wr(3'd2, 8'h00);
      rd_check("R7 plain register took config-mode write", 3'd0, 8'h5A);
   endtask

   task automatic t_fifo_wrap;
      wr(3'd2, 8'hC0);
      rd_check("R4 test mode empty flags", 3'd2, 8'hC1);
      wr(3'd0, 8'h11);
      rd_check("R4 partial flags", 3'd2, 8'hC0);
      wr(3'd0, 8'h22);
      rd_check("R4 full flags", 3'd2, 8'hC2);
      wr(3'd0, 8'h33);
      rd_check("R8 push on full dropped, flags", 3'd2, 8'hC2);
      rd_check("R3 first pop", 3'd0, 8'h11);
      rd_check("R4 partial after pop", 3'd2, 8'hC0);
      wr(3'd0, 8'h44);
      rd_check("R3 full after wrap push", 3'd2, 8'hC2);
      rd_check("R3 second pop order", 3'd0, 8'h22);
      rd_check("R3 wrapped byte pop", 3'd0, 8'h44);
      rd_check("R4 empty after drain", 3'd2, 8'hC1);
      rd_check("R8 pop on empty gives FF", 3'd0, 8'hFF);
      rd_check("R8 flags stay empty", 3'd2, 8'hC1);
   endtask

   task automatic t_flush;
      wr(3'd0, 8'h77);
      wr(3'd2, 8'hDF);
      rd_check("R5 same-mode write keeps flags", 3'd2, 8'hC0);
      rd_check("R5 same-mode write keeps data", 3'd0, 8'h77);
      wr(3'd0, 8'h88);
      wr(3'd0, 8'h99);
      wr(3'd2, 8'h40);
      rd_check("R5 mode change flushes", 3'd2, 8'h41);
      wr(3'd2, 8'hC0);
      rd_check("R5 flushed FIFO pops FF", 3'd0, 8'hFF);
      wr(3'd2, 8'h00);
      rd_check("R6 plain byte unaffected by FIFO traffic", 3'd0, 8'h5A);
   endtask

   task automatic t_unused;
      for (int a = 3; a < 8; a++) begin
         wr(3'(a), 8'h00);
         rd_check("R10 unused location reads FF", 3'(a), 8'hFF);
      end
      rd_check("R10 control unchanged", 3'd2, 8'h01);
      rd_check("R10 cfgB unchanged", 3'd1, 8'h3C);
      rd_check("R10 data unchanged", 3'd0, 8'h5A);
   endtask

   task automatic t_latency;
      wr(3'd1, 8'h96);
      @(negedge clk);
      bus_addr = 3'd1; bus_rd = 1'b1;
      @(posedge clk);
      #1;
      check("R11 updated after edge", bus_rdata, 8'h96);
      @(negedge clk);
      bus_rd = 1'b0;
      bus_addr = 3'd2;
      @(negedge clk);
      @(negedge clk);
      check("R11 holds without read", bus_rdata, 8'h96);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_mode_write();
      t_cfgb();
      t_plain();
      t_config();
      t_fifo_wrap();
      t_flush();
      t_unused();
      t_latency();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule